// File: doc/BRIEF.md
# Virtual-Supervisor Interrupt Enable/Pending Alias Unit

This unit is the interrupt corner of a hypervisor-capable CSR file. It owns the machine-level interrupt enable register, the pending register and the two delegation registers (machine-to-supervisor and hypervisor-to-guest). It also serves the supervisor and virtual-supervisor views of enable and pending. Those views are windows onto the machine registers, not storage of their own.

The virtual-supervisor views move the guest interrupt bits one position down, so a guest sees its software, timer and external interrupts in the ordinary supervisor slots. The hypervisor delegation register gates these views. While the hart runs virtualized (`virt_i` high), the plain supervisor addresses are redirected to the virtual-supervisor views. The CSR port is single-cycle. Read data is combinational and always shows the value before the access. Any write lands on the next clock edge.

Bit layout (fixed, since the aliasing depends on it): supervisor software/timer/external at bits 1/5/9, virtual-supervisor at 2/6/10, machine at 3/7/11. Addresses: mideleg 0x303, mie 0x304, mip 0x344, hideleg 0x603, sie 0x104, sip 0x144, vsie 0x204, vsip 0x244.

Top module: `irq_alias_csr`

## Requirements
- R1: After reset `mie_o`, `mip_o`, `mideleg_o` and `hideleg_o` are zero, and a read of any address returns 0.
- R2: Writes to machine-level mie (0x304) and mip (0x344) keep only bits 1,2,3,5,6,7,9,10,11. mideleg (0x303) keeps only bits 1,5,9 and hideleg (0x603) keeps only bits 2,6,10. A read returns the stored value. mie and mideleg take plain writes. mip is updated only in the bits set in `csr_wmask_i`.
- R3: A vsie read (0x204) returns (mie AND hideleg AND 0x444) shifted right by one.
- R4: A vsie write stores ((wdata << 1) AND hideleg AND 0x444) into mie bits 2,6,10, covering all three guest interrupts. Every other mie bit is left as it was.
- R5: A vsip access changes only mip bit 2. It writes that bit from wdata bit 1, and only when wmask bit 1 and hideleg bit 2 are both set. Guest timer and external pending bits (6,10) are never altered through this view.
- R6: A vsip access returns (mip AND 0x444) >> 1, taken before the update committed by the same access.
- R7: With `virt_i` high, sie (0x104) and sip (0x144) behave exactly as vsie and vsip.
- R8: With `virt_i` low, an sie read returns mie AND mideleg. An sie write replaces only mie bits 1,5,9.
- R9: With `virt_i` low, an sip access returns mip AND mideleg. It updates mip only in the bits of wmask AND mideleg AND 0x2.
- R10: An unrecognised address drives `csr_hit_o` low and returns 0 without changing any register.
- R11: No register changes while `csr_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| virt_i | input | 1 | Hart is running virtualized |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | Access writes |
| csr_wdata_i | input | XLEN | Write data |
| csr_wmask_i | input | XLEN | Bit-write mask for pending views |
| csr_rdata_o | output | XLEN | Pre-update view value |
| csr_hit_o | output | 1 | Address is one of the eight served |
| mie_o | output | XLEN | Machine interrupt enable |
| mip_o | output | XLEN | Machine interrupt pending |
| mideleg_o | output | XLEN | Machine-to-supervisor delegation |
| hideleg_o | output | XLEN | Hypervisor-to-guest delegation |

## Verification
The hardest state to reach is one where hideleg delegates only some guest interrupts while mip already holds guest timer and external bits. Only in that state can the bench tell a hideleg-gated write apart from an ungated one, or a mask of all three guest bits apart from a software-only mask. The stimulus first fills mip through its full machine-level window and narrows hideleg to the timer bit. It then issues guest writes with all-ones data and masks. Next it widens hideleg and clears and restores bit 2 through both the vsip address and the virtualized sip address.

// File: rtl/irq_alias_pkg.sv
package irq_alias_pkg;

  typedef enum logic [3:0] {
    V_NONE, V_MIE, V_MIP, V_MIDELEG, V_HIDELEG, V_SIE, V_SIP, V_VSIE, V_VSIP
  } view_e;

  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_HIDELEG = 12'h603;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_SIP     = 12'h144;
  localparam logic [11:0] A_VSIE    = 12'h204;
  localparam logic [11:0] A_VSIP    = 12'h244;

  // bit slots: software, timer, external per privilege
  localparam int unsigned S_SW = 1, S_TM = 5, S_EX = 9;
  localparam int unsigned GUEST_SHIFT = 1;
  localparam int unsigned M_OFS = 2;

  localparam logic [63:0] S_IRQ  = (64'd1 << S_SW) | (64'd1 << S_TM) | (64'd1 << S_EX);
  localparam logic [63:0] VS_IRQ = S_IRQ << GUEST_SHIFT;
  localparam logic [63:0] M_IRQ  = S_IRQ << M_OFS;
  localparam logic [63:0] ALL_IRQ = S_IRQ | VS_IRQ | M_IRQ;
  localparam logic [63:0] SIP_WR  = 64'd1 << S_SW;
  localparam logic [63:0] VSIP_WR = SIP_WR << GUEST_SHIFT;

endpackage

// File: rtl/irq_alias_decode.sv
module irq_alias_decode
  import irq_alias_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic        virt_i,
  output view_e       sel_o,
  output logic        hit_o
);
  view_e raw;

  always_comb begin
    unique case (addr_i)
      A_MIE:     raw = V_MIE;
      A_MIP:     raw = V_MIP;
      A_MIDELEG: raw = V_MIDELEG;
      A_HIDELEG: raw = V_HIDELEG;
      A_SIE:     raw = V_SIE;
      A_SIP:     raw = V_SIP;
      A_VSIE:    raw = V_VSIE;
      A_VSIP:    raw = V_VSIP;
      default:   raw = V_NONE;
    endcase
  end

  // virtualized hart: supervisor views redirect to guest views
  always_comb begin
    sel_o = raw;
    if (virt_i && raw == V_SIE) sel_o = V_VSIE;
    if (virt_i && raw == V_SIP) sel_o = V_VSIP;
  end

  assign hit_o = (raw != V_NONE);
endmodule

// File: rtl/irq_alias_regs.sv
module irq_alias_regs
  import irq_alias_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  view_e           sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] hideleg_o
);
  localparam logic [XLEN-1:0] SM   = S_IRQ[XLEN-1:0];
  localparam logic [XLEN-1:0] VSM  = VS_IRQ[XLEN-1:0];
  localparam logic [XLEN-1:0] AM   = ALL_IRQ[XLEN-1:0];
  localparam logic [XLEN-1:0] SWR  = SIP_WR[XLEN-1:0];
  localparam logic [XLEN-1:0] VSWR = VSIP_WR[XLEN-1:0];

  logic [XLEN-1:0] mie_q, mip_q, mdl_q, hdl_q;
  logic [XLEN-1:0] mie_d, mip_d, mdl_d, hdl_d;
  logic [XLEN-1:0] wd_up, wm_up, bm;

  assign wd_up = wdata_i << GUEST_SHIFT;
  assign wm_up = wmask_i << GUEST_SHIFT;

  always_comb begin
    mie_d = mie_q;
    mip_d = mip_q;
    mdl_d = mdl_q;
    hdl_d = hdl_q;
    bm    = '0;
    if (wr_i) begin
      unique case (sel_i)
        V_MIE:     mie_d = wdata_i & AM;
        V_MIDELEG: mdl_d = wdata_i & SM;
        V_HIDELEG: hdl_d = wdata_i & VSM;
        V_MIP: begin
          bm    = wmask_i & AM;
          mip_d = (mip_q & ~bm) | (wdata_i & bm);
        end
        V_SIE:     mie_d = (mie_q & ~SM) | (wdata_i & SM);
        V_SIP: begin
          bm    = wmask_i & mdl_q & SWR;
          mip_d = (mip_q & ~bm) | (wdata_i & bm);
        end
        V_VSIE:    mie_d = (mie_q & ~VSM) | (wd_up & hdl_q & VSM);
        V_VSIP: begin
          bm    = wm_up & VSWR & hdl_q;
          mip_d = (mip_q & ~bm) | (wd_up & bm);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q <= '0;
      mip_q <= '0;
      mdl_q <= '0;
      hdl_q <= '0;
    end else begin
      mie_q <= mie_d;
      mip_q <= mip_d;
      mdl_q <= mdl_d;
      hdl_q <= hdl_d;
    end
  end

  assign mie_o     = mie_q;
  assign mip_o     = mip_q;
  assign mideleg_o = mdl_q;
  assign hideleg_o = hdl_q;
endmodule

// File: rtl/irq_alias_view.sv
module irq_alias_view
  import irq_alias_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  view_e           sel_i,
  input  logic [XLEN-1:0] mie_i,
  input  logic [XLEN-1:0] mip_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] hideleg_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam logic [XLEN-1:0] VSM = VS_IRQ[XLEN-1:0];

  always_comb begin
    unique case (sel_i)
      V_MIE:     rdata_o = mie_i;
      V_MIP:     rdata_o = mip_i;
      V_MIDELEG: rdata_o = mideleg_i;
      V_HIDELEG: rdata_o = hideleg_i;
      V_SIE:     rdata_o = mie_i & mideleg_i;
      V_SIP:     rdata_o = mip_i & mideleg_i;
      V_VSIE:    rdata_o = (mie_i & hideleg_i & VSM) >> GUEST_SHIFT;
      V_VSIP:    rdata_o = (mip_i & VSM) >> GUEST_SHIFT;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_alias_csr.sv
module irq_alias_csr
  import irq_alias_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            virt_i,
  input  logic            csr_valid_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [XLEN-1:0] csr_wmask_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_hit_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] hideleg_o
);
  view_e           sel;
  logic            hit, wr;
  logic [XLEN-1:0] rd;

  irq_alias_decode u_dec (
    .addr_i (csr_addr_i),
    .virt_i (virt_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  assign wr = csr_valid_i & csr_we_i & hit;

  irq_alias_regs #(.XLEN(XLEN)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .sel_i     (sel),
    .wdata_i   (csr_wdata_i),
    .wmask_i   (csr_wmask_i),
    .mie_o     (mie_o),
    .mip_o     (mip_o),
    .mideleg_o (mideleg_o),
    .hideleg_o (hideleg_o)
  );

  irq_alias_view #(.XLEN(XLEN)) u_view (
    .sel_i     (sel),
    .mie_i     (mie_o),
    .mip_i     (mip_o),
    .mideleg_i (mideleg_o),
    .hideleg_i (hideleg_o),
    .rdata_o   (rd)
  );

  assign csr_rdata_o = csr_valid_i ? rd : '0;
  assign csr_hit_o   = hit;
endmodule

// File: rtl/irq_alias_chk.sv
module irq_alias_chk
  import irq_alias_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            virt_i,
  input logic            csr_valid_i,
  input logic [11:0]     csr_addr_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            csr_hit_o,
  input logic [XLEN-1:0] mie_o,
  input logic [XLEN-1:0] mip_o,
  input logic [XLEN-1:0] mideleg_o,
  input logic [XLEN-1:0] hideleg_o
);
  localparam logic [XLEN-1:0] SM  = S_IRQ[XLEN-1:0];
  localparam logic [XLEN-1:0] VSM = VS_IRQ[XLEN-1:0];
  localparam logic [XLEN-1:0] B2  = VSIP_WR[XLEN-1:0];

  logic vsie_acc, vsip_acc, sie_host_wr, wr_any;
  assign vsie_acc    = csr_valid_i && (csr_addr_i == A_VSIE || (virt_i && csr_addr_i == A_SIE));
  assign vsip_acc    = csr_valid_i && (csr_addr_i == A_VSIP || (virt_i && csr_addr_i == A_SIP));
  assign sie_host_wr = csr_valid_i && csr_we_i && !virt_i && csr_addr_i == A_SIE;
  assign wr_any      = csr_valid_i && csr_we_i;

  AST_HIDELEG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hideleg_o & ~VSM) == '0);  // R2
  AST_MIDELEG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mideleg_o & ~SM) == '0);  // R2
  AST_VSIE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsie_acc |-> csr_rdata_o == ((mie_o & hideleg_o & VSM) >> 1));  // R3
  AST_VSIE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsie_acc && csr_we_i) |=> ((mie_o & ~VSM) == ($past(mie_o) & ~VSM)));  // R4
  AST_VSIP_ONLY_B2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsip_acc && csr_we_i) |=> ((mip_o & ~B2) == ($past(mip_o) & ~B2)));  // R5
  AST_VSIP_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsip_acc |-> csr_rdata_o == ((mip_o & VSM) >> 1));  // R6
  AST_SIE_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_host_wr |=> ((mie_o & ~SM) == ($past(mie_o) & ~SM)));  // R8
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && !csr_hit_o) |-> csr_rdata_o == '0);  // R10
  AST_MISS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !csr_hit_o) |=> ($stable(mie_o) && $stable(mip_o) && $stable(mideleg_o) && $stable(hideleg_o)));  // R10
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |=> ($stable(mie_o) && $stable(mip_o) && $stable(mideleg_o) && $stable(hideleg_o)));  // R11
endmodule

bind irq_alias_csr irq_alias_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .virt_i      (virt_i),
  .csr_valid_i (csr_valid_i),
  .csr_addr_i  (csr_addr_i),
  .csr_we_i    (csr_we_i),
  .csr_rdata_o (csr_rdata_o),
  .csr_hit_o   (csr_hit_o),
  .mie_o       (mie_o),
  .mip_o       (mip_o),
  .mideleg_o   (mideleg_o),
  .hideleg_o   (hideleg_o)
);

// File: tb/sim_irq_alias_csr.sv
module sim_irq_alias_csr;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NV = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            virt_i = 1'b0;
  logic            csr_valid_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic            csr_we_i = 1'b0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [XLEN-1:0] csr_wmask_i = '0;
  logic [XLEN-1:0] csr_rdata_o, mie_o, mip_o, mideleg_o, hideleg_o;
  logic            csr_hit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_alias_csr #(.XLEN(XLEN)) u0 (.*);

  typedef struct packed {
    logic        virt;
    logic [11:0] addr;
    logic        we;
    logic [31:0] wd;
    logic [31:0] wm;
    logic [31:0] rd;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h304, 1'b1, 32'hFFFF_FFFF, 32'h0,         32'h0,   1'b1}, // 0  R2 mie <- EEE
    '{1'b0, 12'h603, 1'b1, 32'hFFFF_FFFF, 32'h0,         32'h0,   1'b1}, // 1  R2 hideleg <- 444
    '{1'b0, 12'h204, 1'b0, 32'h0,         32'h0,         32'h222, 1'b1}, // 2  R3
    '{1'b0, 12'h303, 1'b1, 32'h0000_0220, 32'h0,         32'h0,   1'b1}, // 3  R2 mideleg <- 220
    '{1'b0, 12'h104, 1'b0, 32'h0,         32'h0,         32'h220, 1'b1}, // 4  R8 read
    '{1'b0, 12'h104, 1'b1, 32'h0,         32'h0,         32'h220, 1'b1}, // 5  R8 mie <- CCC
    '{1'b0, 12'h304, 1'b0, 32'h0,         32'h0,         32'hCCC, 1'b1}, // 6  R8
    '{1'b0, 12'h204, 1'b1, 32'h0,         32'h0,         32'h222, 1'b1}, // 7  R4 mie <- 888
    '{1'b0, 12'h603, 1'b1, 32'h0000_0040, 32'h0,         32'h444, 1'b1}, // 8  R2 hideleg <- 040
    '{1'b0, 12'h204, 1'b1, 32'h0000_0FFF, 32'h0,         32'h0,   1'b1}, // 9  R4 mie <- 8C8
    '{1'b0, 12'h304, 1'b0, 32'h0,         32'h0,         32'h8C8, 1'b1}, // 10 R4 hideleg gating
    '{1'b1, 12'h104, 1'b0, 32'h0,         32'h0,         32'h020, 1'b1}, // 11 R7 sie->vsie
    '{1'b0, 12'h344, 1'b1, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0,   1'b1}, // 12 R2 mip <- EEE
    '{1'b0, 12'h244, 1'b0, 32'h0,         32'h0,         32'h222, 1'b1}, // 13 R6
    '{1'b0, 12'h244, 1'b1, 32'h0,         32'hFFFF_FFFF, 32'h222, 1'b1}, // 14 R5 blocked by hideleg
    '{1'b0, 12'h344, 1'b0, 32'h0,         32'h0,         32'hEEE, 1'b1}, // 15 R5
    '{1'b0, 12'h603, 1'b1, 32'h0000_0444, 32'h0,         32'h040, 1'b1}, // 16 R2 hideleg <- 444
    '{1'b1, 12'h144, 1'b1, 32'h0,         32'h0000_0002, 32'h222, 1'b1}, // 17 R7 R6 mip <- EEA
    '{1'b0, 12'h344, 1'b0, 32'h0,         32'h0,         32'hEEA, 1'b1}, // 18 R5
    '{1'b0, 12'h244, 1'b1, 32'h0000_FFFF, 32'h0,         32'h220, 1'b1}, // 19 R5 zero mask
    '{1'b0, 12'h244, 1'b1, 32'h0000_0002, 32'h0000_0002, 32'h220, 1'b1}, // 20 R6 mip <- EEE
    '{1'b0, 12'h144, 1'b0, 32'h0,         32'h0,         32'h220, 1'b1}, // 21 R9 read
    '{1'b0, 12'h144, 1'b1, 32'h0,         32'hFFFF_FFFF, 32'h220, 1'b1}, // 22 R9 mideleg blocks
    '{1'b0, 12'h303, 1'b1, 32'h0000_0222, 32'h0,         32'h220, 1'b1}, // 23 R2 mideleg <- 222
    '{1'b0, 12'h144, 1'b1, 32'h0,         32'hFFFF_FFFF, 32'h222, 1'b1}, // 24 R9 mip <- EEC
    '{1'b0, 12'h344, 1'b0, 32'h0,         32'h0,         32'hEEC, 1'b1}, // 25 R9
    '{1'b0, 12'h305, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,   1'b0}, // 26 R10
    '{1'b0, 12'h304, 1'b0, 32'h0,         32'h0,         32'h8C8, 1'b1}, // 27 R10 unchanged
    '{1'b1, 12'h104, 1'b1, 32'h0000_0FFF, 32'h0,         32'h020, 1'b1}, // 28 R7 R4 mie <- CCC
    '{1'b0, 12'h304, 1'b0, 32'h0,         32'h0,         32'hCCC, 1'b1}, // 29 R7
    '{1'b0, 12'h344, 1'b1, 32'h0,         32'h0000_0F00, 32'hEEC, 1'b1}, // 30 R2 mip <- 0EC
    '{1'b1, 12'h244, 1'b0, 32'h0,         32'h0,         32'h022, 1'b1}  // 31 R6
  };

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [11:0] a, input logic we,
                       input logic [XLEN-1:0] wd, input logic [XLEN-1:0] wm, input logic vld);
    virt_i = v; csr_addr_i = a; csr_we_i = we;
    csr_wdata_i = wd; csr_wmask_i = wm; csr_valid_i = vld;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 mie", mie_o, '0);
    chk("R1 mip", mip_o, '0);
    chk("R1 mideleg", mideleg_o, '0);
    chk("R1 hideleg", hideleg_o, '0);
    drive(1'b0, 12'h304, 1'b0, '0, '0, 1'b1);
    #1 chk("R1 rdata", csr_rdata_o, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i].virt, VECS[i].addr, VECS[i].we, VECS[i].wd, VECS[i].wm, 1'b1);
      #1;
      chk($sformatf("vec%0d rdata", i), csr_rdata_o, VECS[i].rd);
      chk($sformatf("vec%0d hit", i), {31'b0, csr_hit_o}, {31'b0, VECS[i].hit});
    end

    // R11 idle cycles with write strobes and valid low
    @(negedge clk_i);
    drive(1'b0, 12'h304, 1'b1, '0, '1, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R11 mie", mie_o, 32'hCCC);
    chk("R11 mip", mip_o, 32'h0EC);
    chk("R2 mideleg", mideleg_o, 32'h222);
    chk("R2 hideleg", hideleg_o, 32'h444);

    // R5 direct: vsip all-ones cannot touch bits 6/10
    drive(1'b0, 12'h244, 1'b1, '0, '1, 1'b1);
    @(negedge clk_i);
    drive(1'b0, 12'h244, 1'b1, '1, '1, 1'b1);
    @(negedge clk_i);
    csr_valid_i = 1'b0;
    chk("R5 mip", mip_o, 32'h0EC);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mie async", mie_o, '0);
    chk("R1 mip async", mip_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule